// File: doc/BRIEF.md
# 100BASE-X PCS Receive Framer

This block sits behind the descrambler of a 100 Mb/s receiver. It takes one already descrambled bit per clock and produces the nibble-wide receive signals a MAC expects: a data nibble, a data-valid flag, an error flag and carrier sense. Code groups are 5 bits wide. The first bit in time is the leftmost bit of each code written below.

While the line is quiet, the framer hunts for the start-of-stream pair J (11000) followed by K (10001). When it finds the pair, it locks a divide-by-5 group boundary to it. From then on it converts each group to a nibble, using the 4B5B table: 11110=0, 01001=1, 10100=2, 10101=3, 01010=4, 01011=5, 01110=6, 01111=7, 10010=8, 10011=9, 10110=A, 10111=B, 11010=C, 11011=D, 11100=E, 11101=F. A frame ends cleanly on T (01101) followed by R (00111).

Bursts of activity that do not form the start pair are reported as false carrier. Invalid groups inside a frame, repeated idles inside a frame and loss of descrambler sync are reported as frame errors.

Top module: `pcs_rx_framer`

## Requirements
- R1: Out of reset, and while the line carries only ones, `crs`, `rx_dv` and `rx_er` are low and `rxd` is 0000. Whenever `crs` is low, `rx_dv` and `rx_er` are low.
- R2: On the clock edge that samples the last bit of K, following a complete J, `rx_dv` goes high with `rxd`=0101. `rx_dv` never rises with any other nibble.
- R3: After the start pair, every 5 bits form one group. On the edge that samples a group's last bit, a valid data group sets `rxd` to its nibble per the 4B5B table, with `rx_dv` high and `rx_er` low.
- R4: A T group keeps `rx_dv` high, clears `rx_er` and holds `rxd`. If the next group is R, `rx_dv`, `rx_er`, `crs` and `rxd` all go to zero on that group's last-bit edge.
- R5: On the 7th bit after the first zero of a burst, if the last 10 bits are not J,K and the burst holds two zeros separated by at least one one, the outputs become `rx_er`=1, `rxd`=1110, `rx_dv`=0 with `crs` high.
- R6: After a false carrier, `rx_er` and `crs` stay high until QUIET_BITS consecutive ones (10 by default) are received. Any zero restarts that count. Afterwards everything clears and a new J,K is accepted.
- R7: Inside a frame, a group that is neither data, T, R after T, nor idle sets `rx_er` high with `rx_dv` high and `rxd`=ERR_CODE for one group period. The next valid data group clears `rx_er`.
- R8: An idle group (11111) inside a frame is an error as in R7. A second consecutive idle is also an error, and on the following group's last-bit edge `rx_dv`, `rx_er` and `crs` drop.
- R9: If `sync_lost` is high on any clock of a group inside a frame, that group is reported as an error as in R7.
- R10: A T group followed by any group other than R reports an error as in R7, and the frame continues.
- R11: A burst whose zeros are all adjacent, or a single zero, produces no error. `crs` returns low on the 7th bit after the first zero.
- R12: `crs` goes high on the edge that samples the first zero seen while hunting.
- R13: Once raised, `rx_er` stays high for at least one full group period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Descrambled serial bit, first-in-time bit of a group first |
| sync_lost | input | 1 | Descrambler lost lock; an in-frame error |
| rxd | output | 4 | Received nibble or error code |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| crs | output | 1 | Carrier sense |

## Verification
The bench builds the framer with ERR_CODE=0110, the non-default error nibble. This makes every in-frame error check tell the chosen code apart from the start nibble 0101, which would look the same under the default. QUIET_BITS stays at 10, so the false-carrier release can be checked one bit early and exactly on time, and a zero placed mid-count shows the count restarting. All sixteen data codes, a single zero, adjacent zeros and a split-zero burst reach the group and burst boundaries that the requirements name.

// File: rtl/pcs_rx_framer.sv
module pcs_rx_framer #(
  parameter logic [3:0] ERR_CODE   = 4'b0101,
  parameter int         QUIET_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       sync_lost,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_er,
  output logic       crs
);

  localparam int         QW       = $clog2(QUIET_BITS + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(QUIET_BITS - 1);
  localparam logic [9:0] SSD      = 10'b11000_10001;
  localparam logic [4:0] CG_T     = 5'b01101;
  localparam logic [4:0] CG_R     = 5'b00111;
  localparam logic [4:0] CG_I     = 5'b11111;
  localparam logic [3:0] FC_CODE  = 4'b1110;
  localparam logic [3:0] PRE_CODE = 4'b0101;

  typedef enum logic [1:0] {S_IDLE, S_CAND, S_FRAME, S_FALSE} st_t;

  st_t           st;
  logic [8:0]    sh;
  logic [2:0]    pos;
  logic [QW-1:0] ones;
  logic          t_pend, end_pend, idle1, lost;

  logic [9:0] w;
  logic [4:0] cg;
  logic [4:0] dec;
  logic       fc_hit;

  assign w      = {sh, rx_bit};
  assign cg     = w[4:0];
  assign fc_hit = |(w[7:1] & ~w[6:0]);
  assign crs    = (st != S_IDLE);

  always_comb begin
    case (cg)
      5'b11110: dec = {1'b1, 4'h0};
      5'b01001: dec = {1'b1, 4'h1};
      5'b10100: dec = {1'b1, 4'h2};
      5'b10101: dec = {1'b1, 4'h3};
      5'b01010: dec = {1'b1, 4'h4};
      5'b01011: dec = {1'b1, 4'h5};
      5'b01110: dec = {1'b1, 4'h6};
      5'b01111: dec = {1'b1, 4'h7};
      5'b10010: dec = {1'b1, 4'h8};
      5'b10011: dec = {1'b1, 4'h9};
      5'b10110: dec = {1'b1, 4'hA};
      5'b10111: dec = {1'b1, 4'hB};
      5'b11010: dec = {1'b1, 4'hC};
      5'b11011: dec = {1'b1, 4'hD};
      5'b11100: dec = {1'b1, 4'hE};
      5'b11101: dec = {1'b1, 4'hF};
      default:  dec = 5'b0_0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '1;
      pos      <= '0;
      ones     <= '0;
      t_pend   <= 1'b0;
      end_pend <= 1'b0;
      idle1    <= 1'b0;
      lost     <= 1'b0;
      rxd      <= '0;
      rx_dv    <= 1'b0;
      rx_er    <= 1'b0;
    end else begin
      sh <= w[8:0];
      if (st == S_FRAME && sync_lost) lost <= 1'b1;
      case (st)
        S_IDLE: begin
          if (!rx_bit) begin
            st  <= S_CAND;
            pos <= '0;
          end
        end
        S_CAND: begin
          if (pos == 3'd6) begin
            pos <= '0;
            if (w == SSD) begin
              st       <= S_FRAME;
              rx_dv    <= 1'b1;
              rx_er    <= 1'b0;
              rxd      <= PRE_CODE;
              t_pend   <= 1'b0;
              end_pend <= 1'b0;
              idle1    <= 1'b0;
              lost     <= 1'b0;
            end else if (fc_hit) begin
              st    <= S_FALSE;
              ones  <= '0;
              rx_er <= 1'b1;
              rxd   <= FC_CODE;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            pos <= pos + 3'd1;
          end
        end
        S_FALSE: begin
          if (!rx_bit) begin
            ones <= '0;
          end else if (ones == Q_LAST) begin
            st    <= S_IDLE;
            rx_er <= 1'b0;
            rxd   <= '0;
          end else begin
            ones <= ones + 1'b1;
          end
        end
        S_FRAME: begin
          pos <= (pos == 3'd4) ? 3'd0 : pos + 3'd1;
          if (pos == 3'd4) begin
            lost <= 1'b0;
            if (end_pend) begin
              st    <= S_IDLE;
              rx_dv <= 1'b0;
              rx_er <= 1'b0;
              rxd   <= '0;
            end else if (lost || sync_lost) begin
              rx_er <= 1'b1;
              rxd   <= ERR_CODE;
            end else if (t_pend) begin
              t_pend <= 1'b0;
              if (cg == CG_R) begin
                st    <= S_IDLE;
                rx_dv <= 1'b0;
                rx_er <= 1'b0;
                rxd   <= '0;
              end else begin
                rx_er <= 1'b1;
                rxd   <= ERR_CODE;
              end
            end else if (dec[4]) begin
              rxd   <= dec[3:0];
              rx_er <= 1'b0;
              idle1 <= 1'b0;
            end else if (cg == CG_T) begin
              t_pend <= 1'b1;
              rx_er  <= 1'b0;
              idle1  <= 1'b0;
            end else if (cg == CG_I) begin
              rx_er <= 1'b1;
              rxd   <= ERR_CODE;
              if (idle1) end_pend <= 1'b1;
              idle1 <= 1'b1;
            end else begin
              rx_er <= 1'b1;
              rxd   <= ERR_CODE;
              idle1 <= 1'b0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pcs_rx_framer_chk.sv
module pcs_rx_framer_chk #(
  parameter logic [3:0] ERR_CODE = 4'b0101
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rxd,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       crs
);

  // R1
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !crs |-> (!rx_dv && !rx_er));

  // R2
  sof_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> (rxd == 4'b0101));

  // R5
  false_carrier_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && !rx_dv) |-> (rxd == 4'b1110));

  // R7
  frame_err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && rx_dv) |-> (rxd == ERR_CODE));

  // R13
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_er) |=> rx_er);

endmodule

bind pcs_rx_framer pcs_rx_framer_chk #(.ERR_CODE(ERR_CODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs)
);

// File: tb/pcs_rx_framer_tb_top.sv
module pcs_rx_framer_tb_top;

  localparam logic [3:0] ERR = 4'b0110;
  localparam logic [4:0] CG_J = 5'b11000, CG_K = 5'b10001;
  localparam logic [4:0] CG_T = 5'b01101, CG_R = 5'b00111, CG_I = 5'b11111;
  localparam logic [8:0] DATA_TAB [16] = '{
    {5'b11110, 4'h0}, {5'b01001, 4'h1}, {5'b10100, 4'h2}, {5'b10101, 4'h3},
    {5'b01010, 4'h4}, {5'b01011, 4'h5}, {5'b01110, 4'h6}, {5'b01111, 4'h7},
    {5'b10010, 4'h8}, {5'b10011, 4'h9}, {5'b10110, 4'hA}, {5'b10111, 4'hB},
    {5'b11010, 4'hC}, {5'b11011, 4'hD}, {5'b11100, 4'hE}, {5'b11101, 4'hF}
  };

  logic clk = 1'b0, rst_n = 1'b0, rx_bit = 1'b1, sync_lost = 1'b0;
  logic [3:0] rxd;
  logic rx_dv, rx_er, crs;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pcs_rx_framer #(.ERR_CODE(ERR), .QUIET_BITS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .sync_lost(sync_lost),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs)
  );

  // observed vector: {crs, rx_dv, rx_er, rxd}
  task automatic expect_out(input string tag, input logic [6:0] exp);
    logic [6:0] act;
    act = {crs, rx_dv, rx_er, rxd};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    @(posedge clk);
    #1;
  endtask

  task automatic send_group(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic start_frame(input string tag);
    send_ones(5);
    send_group(CG_J);
    send_group(CG_K);
    expect_out(tag, {3'b110, 4'b0101});
  endtask

  task automatic end_frame(input string tag);
    send_group(CG_T);
    send_group(CG_R);
    expect_out(tag, 7'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 reset", 7'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 20; i++) begin
      send_bit(1'b1);
      expect_out("R1 idle line", 7'b0);
    end

    // R12 / R2: start pair bit by bit
    send_ones(5);
    send_bit(1'b1); send_bit(1'b1);
    expect_out("R12 before first zero", 7'b0);
    send_bit(1'b0);
    expect_out("R12 crs on first zero", {3'b100, 4'b0000});
    send_bit(1'b0); send_bit(1'b0);
    send_group(CG_K);
    expect_out("R2 start pair", {3'b110, 4'b0101});

    // R3: table walk
    for (int i = 0; i < 16; i++) begin
      send_group(DATA_TAB[i][8:4]);
      expect_out($sformatf("R3 data code %0d", i), {3'b110, DATA_TAB[i][3:0]});
    end
    send_group(CG_T);
    expect_out("R4 T holds frame", {3'b110, 4'hF});
    send_group(CG_R);
    expect_out("R4 T,R ends frame", 7'b0);

    // R5: split zeros
    send_ones(10);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    send_ones(5);
    expect_out("R5 false carrier", {3'b101, 4'b1110});

    // R6: quiet count with restart
    send_ones(6);
    send_bit(1'b0);
    send_ones(9);
    expect_out("R6 still held after 9 ones", {3'b101, 4'b1110});
    send_bit(1'b1);
    expect_out("R6 released after 10 ones", 7'b0);
    start_frame("R6 frame after false carrier");
    send_group(5'b01011);
    expect_out("R6 data after false carrier", {3'b110, 4'h5});
    end_frame("R6 end");

    // R11: single zero and adjacent zeros
    send_ones(10);
    send_bit(1'b0);
    expect_out("R12 crs on noise zero", {3'b100, 4'b0000});
    send_ones(7);
    expect_out("R11 single zero ignored", 7'b0);
    send_bit(1'b0); send_bit(1'b0);
    send_ones(6);
    expect_out("R11 adjacent zeros ignored", 7'b0);

    // R7: invalid code in frame
    start_frame("R7 start");
    send_group(5'b10101);
    expect_out("R7 data before error", {3'b110, 4'h3});
    send_group(CG_J);
    expect_out("R7 invalid code", {3'b111, ERR});
    send_group(5'b10110);
    expect_out("R7 recovery", {3'b110, 4'hA});
    end_frame("R7 end");

    // R8: two idles in frame
    start_frame("R8 start");
    send_group(5'b01001);
    send_group(CG_I);
    expect_out("R8 first idle", {3'b111, ERR});
    send_group(CG_I);
    expect_out("R8 second idle", {3'b111, ERR});
    send_ones(5);
    expect_out("R8 frame dropped", 7'b0);
    send_ones(10);
    expect_out("R8 stays idle", 7'b0);

    // R9: sync loss mid group
    start_frame("R9 start");
    send_group(5'b10100);
    send_bit(1'b0);
    sync_lost = 1'b1;
    send_bit(1'b1);
    sync_lost = 1'b0;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    expect_out("R9 sync loss error", {3'b111, ERR});
    send_group(5'b01010);
    expect_out("R9 recovery", {3'b110, 4'h4});
    end_frame("R9 end");

    // R10: T without R
    start_frame("R10 start");
    send_group(5'b10011);
    send_group(CG_T);
    expect_out("R10 T holds", {3'b110, 4'h9});
    send_group(5'b01111);
    expect_out("R10 T then non-R", {3'b111, ERR});
    send_group(5'b10010);
    expect_out("R10 continues", {3'b110, 4'h8});
    end_frame("R10 end");

    send_ones(10);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule